// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block holds one 64-bit register that places a memory-mapped PCIe configuration window in the physical address map. Software updates the register through a simple write port with byte enables. From the register the block derives three things: whether the window is on, how large it is, and its aligned base address. Every incoming memory address is then compared against the window. The block reports a hit and the byte offset into configuration space.

The block also reports where the 32-bit PCI memory hole may begin. That point sits directly above the window while the window is on, and falls back to the reset base while it is off. All decode outputs are combinational from the register. A write therefore takes effect in the first cycle after the clock edge that stores it.

Top module: `cfg_window_decoder`

## Requirements
- R1: While reset is held and after it is released, the register holds 0x0000_0000_B000_0000. In that state the window is off, the hit flag is low and the hole start is 0xB000_0000.
- R2: On a clock edge with the write strobe high, byte lane n of the register (bits 8n+7:8n) takes the write data only if byte enable bit n is set. With the write strobe low, the register does not change.
- R3: Register bits 2:1 select the window length. 00 gives 256 MiB, 01 gives 128 MiB and 10 gives 64 MiB.
- R4: The window base always takes register bits 38:28. Bit 27 is also kept for 128 MiB and 64 MiB windows. Bit 26 is kept only for 64 MiB windows. Bits 25:0 of the base are zero, and register bits 63:39 have no effect on the decode.
- R5: Register bit 0 turns the window on. The length code 11 is reserved: it forces the window off with zero length, whatever bit 0 holds.
- R6: The hit flag is high exactly when the window is on and the 39-bit request address minus the base is less than the length. The offset output is that difference while the hit flag is high, and zero otherwise.
- R7: While the window is on, the hole start equals base plus length, given 40 bits wide. While the window is off, it equals 0xB000_0000.
- R8: Every decode output reflects a register write in the cycle right after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrByteEn | input | 8 | Byte enables for the register write |
| wrData | input | 64 | Register write data |
| reqAddr | input | 39 | Memory request address to decode |
| regOut | output | 64 | Current register contents |
| winEnable | output | 1 | Window is on (enable bit set and length code valid) |
| winBase | output | 39 | Masked, aligned window base |
| hit | output | 1 | Request address falls inside the window |
| offset | output | 28 | Offset of the request address from the base |
| holeStart | output | 40 | Lowest address available to the 32-bit PCI hole |

## Verification
The bench targets the mask interplay first. It writes the same base bits 27:26 under each of the three lengths. A design that widened the mask the wrong way would move the base and report offsets that are off by 64 or 128 MiB. It probes the last byte inside the window, the first byte past it and the byte just below it. An off-by-one in the range compare would show up as a false hit at the window end. It sets the reserved length code with the enable bit high, which must give no hit and a fallen-back hole start. It also uses a top-of-range base, where base plus length needs a 40th bit; a 39-bit adder would wrap the hole start to zero. Partial byte-lane writes, including one that sets only the enable byte, check that untouched lanes keep their value.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int LEN_FIELD_W = 2;
  localparam int NUM_SIZES   = 3;

  // sizeSel[k] set means the window spans 2**(LEN_MAX_LOG2 - k) bytes
  typedef struct packed {
    logic                 winOn;
    logic [NUM_SIZES-1:0] sizeSel;
  } winStrobes_t;
endpackage

// File: rtl/cfg_window_ctrl.sv
module cfg_window_ctrl
  import cfg_window_pkg::*;
#(
  parameter int          REG_W        = 64,
  parameter logic [63:0] DEFAULT_REG  = 64'h0000_0000_B000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [REG_W/8-1:0] wrByteEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   regQ,
  output winStrobes_t        strobes
);
  localparam int LANES = REG_W / 8;

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rst_n)
        regQ[lane*8 +: 8] <= DEFAULT_REG[lane*8 +: 8];
      else if (wrEn && wrByteEn[lane])
        regQ[lane*8 +: 8] <= wrData[lane*8 +: 8];
    end
  end

  logic [LEN_FIELD_W-1:0] lenCode;
  logic                   lenReserved;

  always_comb begin
    lenCode     = regQ[LEN_FIELD_W:1];
    lenReserved = (int'(lenCode) >= NUM_SIZES);
    strobes.winOn   = regQ[0] && !lenReserved;
    strobes.sizeSel = '0;
    for (int k = 0; k < NUM_SIZES; k++)
      if (int'(lenCode) == k) strobes.sizeSel[k] = 1'b1;
  end
endmodule

// File: rtl/cfg_window_dp.sv
module cfg_window_dp
  import cfg_window_pkg::*;
#(
  parameter int          ADDR_W       = 39,
  parameter int          LEN_MAX_LOG2 = 28,
  parameter logic [63:0] DEFAULT_REG  = 64'h0000_0000_B000_0000
) (
  input  logic                    [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:LEN_MAX_LOG2-NUM_SIZES+1] regBase,
  input  winStrobes_t                           strobes,
  output logic                    [ADDR_W-1:0] winBase,
  output logic                    [ADDR_W:0]   winLen,
  output logic                                 hit,
  output logic              [LEN_MAX_LOG2-1:0] offset,
  output logic                    [ADDR_W:0]   holeStart
);
  localparam int LEN_MIN_LOG2 = LEN_MAX_LOG2 - NUM_SIZES + 1;
  localparam int LOW_BITS     = LEN_MAX_LOG2 - LEN_MIN_LOG2;

  logic [LOW_BITS-1:0] keepLow;

  // Keep base bit i when the selected window is no larger than 2**i
  for (genvar j = 0; j < LOW_BITS; j++) begin : gKeep
    localparam int BIT_I = LEN_MIN_LOG2 + j;
    assign keepLow[j] = |(strobes.sizeSel >> (LEN_MAX_LOG2 - BIT_I));
  end

  always_comb begin
    winBase = '0;
    winBase[ADDR_W-1:LEN_MAX_LOG2] = regBase[ADDR_W-1:LEN_MAX_LOG2];
    winBase[LEN_MAX_LOG2-1:LEN_MIN_LOG2] = regBase[LEN_MAX_LOG2-1:LEN_MIN_LOG2] & keepLow;
  end

  always_comb begin
    winLen = '0;
    for (int k = 0; k < NUM_SIZES; k++)
      if (strobes.sizeSel[k]) winLen[LEN_MAX_LOG2-k] = 1'b1;
  end

  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff      = reqAddr - winBase;
    hit       = strobes.winOn && ({1'b0, diff} < winLen);
    offset    = hit ? diff[LEN_MAX_LOG2-1:0] : '0;
    holeStart = strobes.winOn ? ({1'b0, winBase} + winLen) : DEFAULT_REG[ADDR_W:0];
  end
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
  import cfg_window_pkg::*;
#(
  parameter int          REG_W        = 64,
  parameter int          ADDR_W       = 39,
  parameter int          LEN_MAX_LOG2 = 28,
  parameter logic [63:0] DEFAULT_REG  = 64'h0000_0000_B000_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrEn,
  input  logic [REG_W/8-1:0]      wrByteEn,
  input  logic [REG_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]       reqAddr,
  output logic [REG_W-1:0]        regOut,
  output logic                    winEnable,
  output logic [ADDR_W-1:0]       winBase,
  output logic                    hit,
  output logic [LEN_MAX_LOG2-1:0] offset,
  output logic [ADDR_W:0]         holeStart
);
  localparam int LEN_MIN_LOG2 = LEN_MAX_LOG2 - NUM_SIZES + 1;

  winStrobes_t       strobes;
  logic [ADDR_W:0]   winLen;

  cfg_window_ctrl #(
    .REG_W(REG_W), .DEFAULT_REG(DEFAULT_REG)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrByteEn(wrByteEn),
    .wrData(wrData), .regQ(regOut), .strobes(strobes)
  );

  cfg_window_dp #(
    .ADDR_W(ADDR_W), .LEN_MAX_LOG2(LEN_MAX_LOG2), .DEFAULT_REG(DEFAULT_REG)
  ) u_dp (
    .reqAddr(reqAddr), .regBase(regOut[ADDR_W-1:LEN_MIN_LOG2]),
    .strobes(strobes), .winBase(winBase), .winLen(winLen), .hit(hit),
    .offset(offset), .holeStart(holeStart)
  );

  assign winEnable = strobes.winOn;
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter int          REG_W        = 64,
  parameter int          ADDR_W       = 39,
  parameter int          LEN_MAX_LOG2 = 28,
  parameter logic [63:0] DEFAULT_REG  = 64'h0000_0000_B000_0000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wrEn,
  input logic [REG_W-1:0]        regOut,
  input logic                    winEnable,
  input logic [ADDR_W-1:0]       winBase,
  input logic [ADDR_W-1:0]       reqAddr,
  input logic                    hit,
  input logic [LEN_MAX_LOG2-1:0] offset,
  input logic [ADDR_W:0]         holeStart
);
  localparam int LEN_MIN_LOG2 = LEN_MAX_LOG2 - 2;

  assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (regOut == DEFAULT_REG[REG_W-1:0]));

  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(regOut));

  assert_base_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    winBase[LEN_MIN_LOG2-1:0] == '0);

  assert_reserved_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (regOut[2:1] == 2'b11) |-> !winEnable);

  assert_hit_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> winEnable);

  assert_offset_consistent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (reqAddr == winBase + ADDR_W'(offset)));

  assert_hole_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !winEnable |-> (holeStart == DEFAULT_REG[ADDR_W:0]));

  assert_hole_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
    winEnable |-> (holeStart > {1'b0, winBase}));
endmodule

bind cfg_window_decoder cfg_window_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .LEN_MAX_LOG2(LEN_MAX_LOG2), .DEFAULT_REG(DEFAULT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regOut(regOut), .winEnable(winEnable),
  .winBase(winBase), .reqAddr(reqAddr), .hit(hit), .offset(offset), .holeStart(holeStart)
);

// File: tb/cfg_window_decoder_tb.sv
module cfg_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrByteEn = '0;
  logic [63:0] wrData = '0;
  logic [38:0] reqAddr = '0;
  logic [63:0] regOut;
  logic        winEnable;
  logic [38:0] winBase;
  logic        hit;
  logic [27:0] offset;
  logic [39:0] holeStart;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cfg_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrByteEn(wrByteEn), .wrData(wrData),
    .reqAddr(reqAddr), .regOut(regOut), .winEnable(winEnable), .winBase(winBase),
    .hit(hit), .offset(offset), .holeStart(holeStart)
  );

  localparam int NV = 11;
  localparam logic [63:0] V_REG [NV] = '{
    64'h0000_0000_B000_0001, 64'h0000_0000_B000_0001, 64'h0000_0000_B000_0001,
    64'h0000_0000_B800_0003, 64'h0000_0000_BC00_0005, 64'h0000_0000_BC00_0001,
    64'h0000_0000_BC00_0003, 64'h0000_0000_E000_0007, 64'h0000_0000_E000_0000,
    64'h0000_0040_0000_0001, 64'hFFFF_FFFF_FFFF_FFFD };
  localparam logic [38:0] V_ADDR [NV] = '{
    39'h00_B012_3456, 39'h00_C000_0000, 39'h00_AFFF_FFFF,
    39'h00_BFFF_FFFF, 39'h00_BC00_0000, 39'h00_BC00_0010,
    39'h00_BC00_0010, 39'h00_E000_0000, 39'h00_E000_0000,
    39'h40_0000_0020, 39'h7F_FFFF_FFFF };
  localparam logic V_HIT [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [27:0] V_OFF [NV] = '{
    28'h012_3456, 28'h0, 28'h0, 28'h7FF_FFFF, 28'h0, 28'hC00_0010,
    28'h400_0010, 28'h0, 28'h0, 28'h20, 28'h3FF_FFFF };
  localparam logic [39:0] V_HOLE [NV] = '{
    40'h00_C000_0000, 40'h00_C000_0000, 40'h00_C000_0000,
    40'h00_C000_0000, 40'h00_C000_0000, 40'h00_C000_0000,
    40'h00_C000_0000, 40'h00_B000_0000, 40'h00_B000_0000,
    40'h40_1000_0000, 40'h80_0000_0000 };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [63:0] d, input logic [7:0] be, input logic en);
    @(negedge clk);
    wrEn = en; wrByteEn = be; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = '0;
  endtask

  task automatic probe(input logic [38:0] a);
    reqAddr = a;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: register and outputs while reset is held
    probe(39'h00_B000_0000);
    check("R1", "regOut in reset", regOut, 64'h0000_0000_B000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    probe(39'h00_B000_0000);
    check("R1", "regOut after reset", regOut, 64'h0000_0000_B000_0000);
    check("R1", "winEnable after reset", {63'b0, winEnable}, 64'h0);
    check("R1", "hit after reset", {63'b0, hit}, 64'h0);
    check("R1", "holeStart after reset", {24'b0, holeStart}, 64'hB000_0000);

    // Vector table: R3 lengths, R4 masking, R5 enable, R6 hit/offset, R7 hole
    for (int i = 0; i < NV; i++) begin
      writeReg(V_REG[i], 8'hFF, 1'b1);
      probe(V_ADDR[i]);
      check("R6", $sformatf("hit vec%0d", i), {63'b0, hit}, {63'b0, V_HIT[i]});
      check("R6", $sformatf("offset vec%0d", i), {36'b0, offset}, {36'b0, V_OFF[i]});
      check("R7", $sformatf("holeStart vec%0d", i), {24'b0, holeStart}, {24'b0, V_HOLE[i]});
    end
    check("R3", "64 MiB end hole", {24'b0, holeStart}, 64'h80_0000_0000);

    // R4: the bits 27:26 of the base kept or dropped per length
    writeReg(64'h0000_0000_BC00_0001, 8'hFF, 1'b1);
    check("R4", "base 256 MiB", {25'b0, winBase}, 64'hB000_0000);
    writeReg(64'h0000_0000_BC00_0003, 8'hFF, 1'b1);
    check("R4", "base 128 MiB", {25'b0, winBase}, 64'hB800_0000);
    writeReg(64'hFFFF_FF80_BC3F_FFF5, 8'hFF, 1'b1);
    check("R4", "base 64 MiB, upper and low bits ignored", {25'b0, winBase}, 64'hBC00_0000);

    // R2 and R5: single-lane write and the reserved code
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    writeReg(64'hFFFF_FFFF_FFFF_FFFF, 8'h01, 1'b1);
    check("R2", "lane 0 only", regOut, 64'h0000_0000_B000_00FF);
    check("R5", "reserved code disables", {63'b0, winEnable}, 64'h0);
    probe(39'h00_B000_0000);
    check("R5", "reserved code no hit", {63'b0, hit}, 64'h0);
    check("R5", "reserved code hole fallback", {24'b0, holeStart}, 64'hB000_0000);
    writeReg(64'h0, 8'hFF, 1'b0);
    check("R2", "strobe low keeps register", regOut, 64'h0000_0000_B000_00FF);
    writeReg(64'h0000_0000_0000_0001, 8'h01, 1'b1);
    probe(39'h00_B000_0000);
    check("R8", "enable visible next cycle", {63'b0, hit}, 64'h1);
    writeReg(64'h0000_0040_0000_0000, 8'h10, 1'b1);
    check("R2", "lane 4 only", regOut, 64'h0000_0040_B000_0001);
    probe(39'h40_B000_0004);
    check("R8", "moved base hit", {63'b0, hit}, 64'h1);
    check("R7", "moved base hole", {24'b0, holeStart}, 64'h40_C000_0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule